// File: doc/BRIEF.md
# Byte-Wide SPI Master with Selectable Sampling Edge

This block is the serial-bus master of a small processor subsystem. Software writes a control word and then a transmit byte. The block shifts the byte out most significant bit first on MOSI and samples MISO for each bit. The serial clock comes from a programmable divider. Its idle level and the edge used to sample MISO are two independent settings, so all four classic clock modes, and their mirrored variants, can be reached without rewiring. Chip select is not part of this block: a general-purpose pin drives it.

Received bits do not land in a one-byte buffer. They are pushed into a wide shift register. With the default width of 32 bits, four back-to-back transfers fill one word, and the most recent byte sits in the low eight bits. A busy flag frames each transfer. While it is high, writes to the control word and to the transmit byte are dropped.

Top module: `spi_xfer_master`

## Requirements
- R1: The control word is `cfg_wdata[0]` = enable, `[1]` = clock idle level, `[2]` = sample on rising edge, and `[PRE_W+2:3]` = divider value N. A control write takes effect only when `busy` is low. Control writes made while `busy` is high are dropped.
- R2: A `tx_wr` pulse while `busy` is low and the block is enabled starts a transfer, and `busy` reads 1 in the next cycle. A `tx_wr` made while busy or while disabled is ignored.
- R3: Each SCK half-period lasts N+1 clock cycles. A transfer makes exactly 16 SCK edges, so `busy` stays high for 16·(N+1) cycles, and SCK ends at its idle level.
- R4: Whenever no transfer is running, including while disabled, SCK sits at the programmed idle level. It follows a new setting one cycle after the control register changes.
- R5: MISO is sampled on rising SCK edges when the sampling bit is 1 and on falling edges when it is 0, whatever the idle level. A transfer takes exactly 8 samples.
- R6: MOSI carries the byte MSB first. Bit 7 is valid from the cycle after the start, and MOSI changes only on SCK edges of the non-sampling direction.
- R7: Each sampled MISO bit enters `rx_word[0]` and moves the older bits one place up. After four transfers, the oldest byte is in `rx_word[31:24]` and the newest in `[7:0]`.
- R8: `busy` falls in the cycle after the 16th SCK edge is produced and stays low for at least one cycle. A transmit write made in that low cycle is accepted.
- R9: Synchronous reset clears SCK, MOSI, `busy` and `rx_word` to 0 and leaves the block disabled with idle level 0, falling-edge sampling and N = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | PRE_W+3 | Control word: enable, idle level, sampling edge, divider |
| tx_wr | input | 1 | Transmit byte write strobe, starts a transfer |
| tx_data | input | 8 | Byte to send |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | High while a transfer is running |
| rx_word | output | RX_W | Accumulated received bits, newest at bit 0 |

## Verification
The bench covers every pairing of idle level and sampling edge at more than one divider value, since each pairing has its own sample and shift edges. A design that tied sampling to the leading edge would capture the wrong bit in two of the four pairings. A design that shifted MOSI on the first leading edge would lose bit 7 when sampling on trailing edges. Writes to the transmit byte and to the control word are made in the middle of a transfer. A design that honoured them would stretch or shorten the busy window, or switch the divider of the next transfer. Four transfers with constant MISO levels pin down the byte order of the receive word, which catches a shift toward the wrong end. The half-period count is checked at divider 0 to catch an off-by-one in the divider.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int FRAME_BITS = 8;
    localparam int EDGE_COUNT = 2 * FRAME_BITS;
    localparam int EDGE_W     = $clog2(EDGE_COUNT);
    localparam int MODE_BITS  = 3;

    // Low bits of the control word, bit 0 first: enable, idle level, sampling edge.
    typedef struct packed {
        logic samp_rise;
        logic cpol;
        logic enable;
    } spim_mode_t;

    // One divider step as seen by the shifter and the sequencer.
    typedef struct packed {
        logic tick;     // an SCK edge is made at the end of this cycle
        logic leading;  // that edge leaves the idle level
        logic first;    // it is edge number 0 of the transfer
        logic last;     // it is the final edge of the transfer
    } spim_edge_t;

    // Sampling happens on leading edges when the rising edge is chosen with idle-low,
    // or the falling edge is chosen with idle-high.
    function automatic logic sample_on_leading(spim_mode_t m);
        return m.samp_rise ^ m.cpol;
    endfunction

endpackage

// File: rtl/spim_sck_gen.sv
module spim_sck_gen
    import spim_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cpol,
    input  logic [PRE_W-1:0] pre,
    output logic             sck,
    output spim_edge_t       ev
);

    logic [PRE_W-1:0]  cnt_q;
    logic [EDGE_W-1:0] idx_q;
    logic              sck_q;
    logic              hit_w;

    always_comb begin
        hit_w      = run && (cnt_q == pre);
        ev.tick    = hit_w;
        ev.leading = ~idx_q[0];
        ev.first   = (idx_q == '0);
        ev.last    = (idx_q == EDGE_W'(EDGE_COUNT - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
            sck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            idx_q <= '0;
            sck_q <= cpol;
        end else if (hit_w) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sck = sck_q;

    // SCK may only move on a divider tick while a transfer runs.
    assert_sck_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !hit_w) |=> $stable(sck_q));

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int RX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_data,
    input  spim_edge_t            ev,
    input  logic                  samp_lead,
    input  logic                  miso,
    output logic                  mosi,
    output logic [RX_W-1:0]       rx_word
);

    logic [FRAME_BITS-1:0] tx_q;
    logic [RX_W-1:0]       rx_q;
    logic                  take_w;
    logic                  move_w;

    always_comb begin
        take_w = ev.tick && (ev.leading == samp_lead);
        // The first edge never moves MOSI: bit 7 is already on the line.
        move_w = ev.tick && (ev.leading != samp_lead) && !ev.first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (move_w) begin
            tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (take_w) begin
            rx_q <= {rx_q[RX_W-2:0], miso};
        end
    end

    assign mosi    = tx_q[FRAME_BITS-1];
    assign rx_word = rx_q;

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !take_w |=> $stable(rx_q));

    assert_msb_first_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (mosi == $past(load_data[FRAME_BITS-1])));

    assert_no_move_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
        (take_w && !load) |=> $stable(tx_q));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spim_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int RX_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [PRE_W+MODE_BITS-1:0] cfg_wdata,
    input  logic                       tx_wr,
    input  logic [FRAME_BITS-1:0]      tx_data,
    input  logic                       miso,
    output logic                       sck,
    output logic                       mosi,
    output logic                       busy,
    output logic [RX_W-1:0]            rx_word
);

    localparam int CFG_W = PRE_W + MODE_BITS;

    spim_mode_t       mode_q;
    logic [PRE_W-1:0] pre_q;
    logic             busy_q;
    logic             cfg_take_w;
    logic             start_w;
    logic             sck_w;
    spim_edge_t       ev_w;

    always_comb begin
        cfg_take_w = cfg_wr && !busy_q;
        start_w    = tx_wr && !busy_q && mode_q.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pre_q  <= '0;
        end else if (cfg_take_w) begin
            mode_q <= spim_mode_t'(cfg_wdata[MODE_BITS-1:0]);
            pre_q  <= cfg_wdata[CFG_W-1:MODE_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (start_w) begin
            busy_q <= 1'b1;
        end else if (ev_w.tick && ev_w.last) begin
            busy_q <= 1'b0;
        end
    end

    spim_sck_gen #(
        .PRE_W(PRE_W)
    ) u_sck_gen (
        .clk (clk),
        .rst (rst),
        .run (busy_q),
        .cpol(mode_q.cpol),
        .pre (pre_q),
        .sck (sck_w),
        .ev  (ev_w)
    );

    spim_shift #(
        .RX_W(RX_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start_w),
        .load_data(tx_data),
        .ev       (ev_w),
        .samp_lead(sample_on_leading(mode_q)),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    assign sck  = sck_w;
    assign busy = busy_q;

    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> ($stable(pre_q) && $stable(mode_q)));

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(tx_wr && mode_q.enable));

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && $past(!busy_q)) |-> (sck_w == $past(mode_q.cpol)));

    assert_end_at_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (sck_w == mode_q.cpol));

endmodule

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 10;
    localparam int RX_W       = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [PRE_W+2:0] cfg_wdata = '0;
    logic             tx_wr = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             miso = 1'b0;
    logic             sck;
    logic             mosi;
    logic             busy;
    logic [RX_W-1:0]  rx_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Stimulus state for MISO
    bit          miso_rand = 1'b1;
    logic        miso_level = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Settings as the bench last wrote them (used for explicit checks)
    int cur_cpol = 0, cur_srise = 0, cur_pre = 0;

    // Reference model state
    int         m_en, m_cpol, m_srise, m_pre, m_busy, m_k, m_shifts, m_e;
    logic       m_sck;
    logic [7:0] m_data;
    logic [RX_W-1:0] m_rx;

    spi_xfer_master #(.PRE_W(PRE_W), .RX_W(RX_W)) i_spi_xfer_master (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(busy), .rx_word(rx_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = miso_rand ? lfsr[0] : miso_level;
    end

    // Behavioural reference: a transfer is measured in cycles elapsed since its start.
    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_cpol = 0; m_srise = 0; m_pre = 0; m_busy = 0;
            m_k = 0; m_shifts = 0; m_sck = 1'b0; m_data = '0; m_rx = '0;
        end else if (m_busy == 0) begin
            m_sck = m_cpol[0];
            if (tx_wr && m_en != 0) begin
                m_busy = 1; m_data = tx_data; m_k = 0; m_shifts = 0;
            end
            if (cfg_wr) begin
                m_en    = int'(cfg_wdata[0]);
                m_cpol  = int'(cfg_wdata[1]);
                m_srise = int'(cfg_wdata[2]);
                m_pre   = int'(cfg_wdata[PRE_W+2:3]);
            end
        end else begin
            if (m_k % (m_pre + 1) == m_pre) begin
                m_e = m_k / (m_pre + 1);
                m_sck = ~m_sck;
                if (((m_e % 2) == 0) == ((m_srise ^ m_cpol) != 0))
                    m_rx = {m_rx[RX_W-2:0], miso};
                else if (m_e != 0)
                    m_shifts = m_shifts + 1;
                if (m_e == 15) m_busy = 0;
            end
            m_k = m_k + 1;
        end
    end

    function automatic logic exp_mosi();
        return (m_shifts < 8) ? m_data[7 - m_shifts] : 1'b0;
    endfunction

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks += 4;
            if (sck !== m_sck) begin
                errors++; $display("FAIL R3 sck actual %0b expected %0b at %0t", sck, m_sck, $time);
            end
            if (mosi !== exp_mosi()) begin
                errors++; $display("FAIL R6 mosi actual %0b expected %0b at %0t", mosi, exp_mosi(), $time);
            end
            if (busy !== (m_busy != 0)) begin
                errors++; $display("FAIL R8 busy actual %0b expected %0b at %0t", busy, (m_busy != 0), $time);
            end
            if (rx_word !== m_rx) begin
                errors++; $display("FAIL R5 rx_word actual %h expected %h at %0t", rx_word, m_rx, $time);
            end
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int en, input int cpol, input int srise, input int pre);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = {PRE_W'(pre), 1'(srise), 1'(cpol), 1'(en)};
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_cpol = cpol; cur_srise = srise; cur_pre = pre;
    endtask

    task automatic do_xfer(input logic [7:0] d);
        int len = 0;
        int nb = 0;
        logic [7:0] bits = '0;
        logic prev_sck, prev_mosi, slev;
        slev = 1'(cur_srise);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
        prev_sck = sck; prev_mosi = mosi;
        while (busy === 1'b1 && len < 100000) begin
            len++;
            @(negedge clk);
            if (sck !== prev_sck && sck === slev) begin
                bits = {bits[6:0], prev_mosi};
                nb++;
            end
            prev_sck = sck; prev_mosi = mosi;
        end
        check_eq("R3 busy length", 32'(len), 32'(16 * (cur_pre + 1)));
        check_eq("R5 sample count", 32'(nb), 32'd8);
        check_eq("R6 bits seen by slave", {24'd0, bits}, {24'd0, d});
        check_eq("R8 busy low after transfer", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check_eq("R9 sck", {31'd0, sck}, 32'd0);
        check_eq("R9 mosi", {31'd0, mosi}, 32'd0);
        check_eq("R9 busy", {31'd0, busy}, 32'd0);
        check_eq("R9 rx_word", rx_word, 32'd0);
        // R9: reset leaves the block disabled, so a write starts nothing
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'hAA;
        @(negedge clk); tx_wr = 1'b0;
        check_eq("R9 disabled after reset", {31'd0, busy}, 32'd0);

        // R4 / R2: disabled with idle-high clock
        set_cfg(0, 1, 0, 0);
        @(negedge clk);
        check_eq("R4 idle level while disabled", {31'd0, sck}, 32'd1);
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h5A;
        @(negedge clk); tx_wr = 1'b0;
        @(negedge clk);
        check_eq("R2 write ignored while disabled", {31'd0, busy}, 32'd0);
        check_eq("R2 mosi untouched while disabled", {31'd0, mosi}, 32'd0);

        // All clock pairings at two divider settings
        for (int pre = 0; pre < 3; pre += 2) begin
            for (int mode = 0; mode < 4; mode++) begin
                set_cfg(1, mode % 2, mode / 2, pre);
                do_xfer(8'hC3 ^ 8'(mode * 17 + pre));
                do_xfer(8'h81 + 8'(mode));
            end
        end

        // R7: byte order of the receive word with constant MISO per transfer
        set_cfg(1, 0, 1, 0);
        miso_rand = 1'b0;
        miso_level = 1'b1; do_xfer(8'h11);
        miso_level = 1'b0; do_xfer(8'h22);
        miso_level = 1'b1; do_xfer(8'h33);
        miso_level = 1'b1; do_xfer(8'h44);
        @(negedge clk);
        check_eq("R7 four bytes accumulated", rx_word, 32'hFF00FFFF);
        miso_rand = 1'b1;

        // R1 / R2: writes during a transfer are dropped
        set_cfg(1, 1, 1, 1);
        begin
            int len = 1;
            @(negedge clk); tx_wr = 1'b1; tx_data = 8'h3C;
            @(negedge clk); tx_wr = 1'b0;
            repeat (5) begin @(negedge clk); len++; end
            tx_wr = 1'b1; tx_data = 8'hFF;
            cfg_wr = 1'b1; cfg_wdata = {PRE_W'(5), 1'b0, 1'b0, 1'b1};
            @(negedge clk); len++;
            tx_wr = 1'b0; cfg_wr = 1'b0;
            while (busy === 1'b1 && len < 1000) begin @(negedge clk); len++; end
            check_eq("R2 busy window not restarted", 32'(len - 1), 32'd32);
            check_eq("R1 idle level kept after dropped write", {31'd0, sck}, 32'd1);
        end
        do_xfer(8'h96);  // length check inside confirms the divider did not change (R1)

        // R8: back-to-back transfers with a one-cycle gap
        set_cfg(1, 0, 0, 0);
        do_xfer(8'hE7);
        do_xfer(8'h18);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule